// File: doc/BRIEF.md
# Host-to-PCI Cycle Type Classifier

This block sits between the processor bus interface and the PCI master engine of a host bridge. For every processor access aimed at the PCI side it decides which kind of PCI cycle the access turns into. It also produces the address phase value for configuration cycles. The choices are interrupt-acknowledge, special cycle, type 0 configuration, type 1 configuration, processor transaction error, or plain pass-through. The result is registered and appears one clock after the access is presented. The PCI master engine uses it to pick the command and the address to drive.

Two access strobes feed the block. The first marks an ordinary processor access, which carries an address, a read/write flag and the active address map. The second marks a write to the configuration-data register. For that write the block decodes the configuration-address register value that is presented alongside it. An interrupt-acknowledge window is selected by the address map. A configuration-data write addressed to the all-ones device and function, register zero, on the local bus, is turned into a broadcast special cycle.

Top module: `hpc_cycle_classifier`

## Requirements
- R1: While rst_ni is low, cyc_type_o and cfg_addr_o are zero; reset acts asynchronously.
- R2: With map_b_i=0, a processor read (acc_valid_i=1, acc_wr_i=0) with address 0xBFFF_FFF0..0xBFFF_FFFF gives interrupt-acknowledge (cyc_type_o bit 1). Addresses just outside that range, and reads in the map B window, give pass-through (bit 0).
- R3: With map_b_i=1, a processor read with address 0xFEF0_0000..0xFEFF_FFFF gives interrupt-acknowledge (bit 1). Addresses outside that range, and addresses in the map A window, give pass-through (bit 0).
- R4: A processor write that hits the window of the active map gives processor transaction error (bit 5). A write outside the active window gives pass-through. cfg_addr_o is zero for both.
- R5: A configuration-data write (cfg_data_wr_i=1) gives special cycle (bit 2) with cfg_addr_o zero only when all of the following hold in cfg_addr_i: enable bit 31 is 1, bus bits 23:16 are 0x00, device bits 15:11 are 0b11111, function bits 10:8 are 0b111, and register bits 7:2 are 0.
- R6: A configuration-data write with enable set and a bus number other than 0x00 gives type 1 configuration (bit 4). In that case cfg_addr_o = {8'h00, bus, device, function, register, 2'b01}.
- R7: A configuration-data write with enable set, bus 0x00, and not the special pattern gives type 0 configuration (bit 3). In that case cfg_addr_o holds a single device-select bit at position 11+device (no bit when device is 21 or more), the function in bits 10:8, the register in bits 7:2, and 2'b00 in bits 1:0.
- R8: A configuration-data write with enable bit 31 clear gives pass-through (bit 0) with cfg_addr_o zero.
- R9: cyc_type_o is one-hot one clock after any strobe, and all zero (with cfg_addr_o zero) one clock after a cycle with neither strobe.
- R10: When cfg_data_wr_i is high, the configuration path decides the result, whatever acc_valid_i, acc_wr_i or acc_addr_i hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | Processor access strobe |
| acc_wr_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | 32 | Processor address |
| map_b_i | input | 1 | Address map select: 0 = map A, 1 = map B |
| cfg_data_wr_i | input | 1 | Write to configuration-data register |
| cfg_addr_i | input | 32 | Configuration-address register contents |
| cyc_type_o | output | 6 | One-hot type: 0 pass, 1 int-ack, 2 special, 3 cfg0, 4 cfg1, 5 error |
| cfg_addr_o | output | 32 | Translated configuration address |

## Verification
The block has no state beyond its output register, so any fault in the decode shows at the ports on the very next clock. It shows as the wrong one-hot bit, as two bits at once, or as a mangled address phase. Window-edge addresses on both maps, the near-miss configuration patterns, device numbers at the edge of the select field, and collisions between the two strobes are each compared one clock after they are presented. A stale or missing register update shows when back-to-back accesses of different types are compared cycle by cycle.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
  localparam int ADDR_W   = 32;
  localparam int BUS_W    = 8;
  localparam int DEV_W    = 5;
  localparam int FN_W     = 3;
  localparam int REG_W    = 6;
  localparam int NUM_CT   = 6;
  localparam int IDSEL_LSB = 11;
  localparam int NUM_DEV  = 1 << DEV_W;

  localparam int CT_PASS = 0;
  localparam int CT_IACK = 1;
  localparam int CT_SPEC = 2;
  localparam int CT_CFG0 = 3;
  localparam int CT_CFG1 = 4;
  localparam int CT_ERR  = 5;

  typedef logic [NUM_CT-1:0] cyc_type_t;

  typedef struct packed {
    logic             en;
    logic [BUS_W-1:0] bus;
    logic [DEV_W-1:0] dev;
    logic [FN_W-1:0]  fn;
    logic [REG_W-1:0] regn;
  } cfg_fields_t;

  function automatic cfg_fields_t unpack_cfg(input logic [ADDR_W-1:0] v);
    cfg_fields_t f;
    f.en   = v[31];
    f.bus  = v[23:16];
    f.dev  = v[15:11];
    f.fn   = v[10:8];
    f.regn = v[7:2];
    return f;
  endfunction
endpackage

// File: rtl/hpc_iack_dec.sv
module hpc_iack_dec
  import hpc_pkg::*;
#(
  parameter logic [ADDR_W-1:0] WIN_A_BASE = 32'hBFFF_FFF0,
  parameter int                WIN_A_LOG2 = 4,
  parameter logic [ADDR_W-1:0] WIN_B_BASE = 32'hFEF0_0000,
  parameter int                WIN_B_LOG2 = 20
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              map_b_i,
  output logic              hit_o
);
  localparam int NUM_MAP = 2;
  localparam logic [ADDR_W-1:0] BASES [NUM_MAP] = '{WIN_A_BASE, WIN_B_BASE};
  localparam int                LOG2S [NUM_MAP] = '{WIN_A_LOG2, WIN_B_LOG2};

  logic [NUM_MAP-1:0] win_hit;

  for (genvar m = 0; m < NUM_MAP; m++) begin : g_win
    localparam logic [ADDR_W-1:0] MASK = ~((ADDR_W'(1) << LOG2S[m]) - ADDR_W'(1));
    assign win_hit[m] = (addr_i & MASK) == (BASES[m] & MASK);
  end

  assign hit_o = map_b_i ? win_hit[1] : win_hit[0];
endmodule

// File: rtl/hpc_cfg_dec.sv
module hpc_cfg_dec
  import hpc_pkg::*;
(
  input  logic [ADDR_W-1:0] cfg_addr_i,
  output logic              off_o,
  output logic              spec_o,
  output logic              cfg0_o,
  output logic              cfg1_o,
  output logic [ADDR_W-1:0] xaddr_o
);
  localparam int LOW_W = FN_W + REG_W + 2;

  cfg_fields_t f;
  logic        local_bus;
  logic        spec_pat;
  logic [ADDR_W-1:0] idsel_vec;
  logic [ADDR_W-1:0] addr0;
  logic [ADDR_W-1:0] addr1;

  assign f         = unpack_cfg(cfg_addr_i);
  assign local_bus = (f.bus == '0);
  assign spec_pat  = (&f.dev) && (&f.fn) && (f.regn == '0);

  assign off_o  = !f.en;
  assign spec_o = f.en && local_bus && spec_pat;
  assign cfg0_o = f.en && local_bus && !spec_pat;
  assign cfg1_o = f.en && !local_bus;

  // device select: one bit per device that fits above IDSEL_LSB
  for (genvar b = 0; b < ADDR_W; b++) begin : g_idsel
    if (b >= IDSEL_LSB && (b - IDSEL_LSB) < NUM_DEV) begin : g_on
      assign idsel_vec[b] = (f.dev == DEV_W'(b - IDSEL_LSB));
    end else begin : g_off
      assign idsel_vec[b] = 1'b0;
    end
  end

  assign addr0 = idsel_vec | {{(ADDR_W-LOW_W){1'b0}}, f.fn, f.regn, 2'b00};
  assign addr1 = {{(ADDR_W-BUS_W-DEV_W-LOW_W){1'b0}}, f.bus, f.dev, f.fn, f.regn, 2'b01};

  always_comb begin
    xaddr_o = '0;
    if (cfg0_o) xaddr_o = addr0;
    if (cfg1_o) xaddr_o = addr1;
  end
endmodule

// File: rtl/hpc_type_sel.sv
module hpc_type_sel
  import hpc_pkg::*;
(
  input  logic              acc_valid_i,
  input  logic              acc_wr_i,
  input  logic              iack_hit_i,
  input  logic              cfg_data_wr_i,
  input  logic              off_i,
  input  logic              spec_i,
  input  logic              cfg0_i,
  input  logic              cfg1_i,
  input  logic [ADDR_W-1:0] xaddr_i,
  output cyc_type_t         type_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_comb begin
    type_o = '0;
    addr_o = '0;
    if (cfg_data_wr_i) begin
      // config path wins over a concurrent processor strobe
      type_o[CT_PASS] = off_i;
      type_o[CT_SPEC] = spec_i;
      type_o[CT_CFG0] = cfg0_i;
      type_o[CT_CFG1] = cfg1_i;
      addr_o          = xaddr_i;
    end else if (acc_valid_i) begin
      type_o[CT_ERR]  = iack_hit_i && acc_wr_i;
      type_o[CT_IACK] = iack_hit_i && !acc_wr_i;
      type_o[CT_PASS] = !iack_hit_i;
    end
  end
endmodule

// File: rtl/hpc_cycle_classifier.sv
module hpc_cycle_classifier
  import hpc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic              acc_wr_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              map_b_i,
  input  logic              cfg_data_wr_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  output logic [NUM_CT-1:0] cyc_type_o,
  output logic [ADDR_W-1:0] cfg_addr_o
);
  logic              iack_hit;
  logic              off, spec, cfg0, cfg1;
  logic [ADDR_W-1:0] xaddr;
  cyc_type_t         type_d;
  logic [ADDR_W-1:0] addr_d;

  hpc_iack_dec u_iack (
    .addr_i  (acc_addr_i),
    .map_b_i (map_b_i),
    .hit_o   (iack_hit)
  );

  hpc_cfg_dec u_cfg (
    .cfg_addr_i (cfg_addr_i),
    .off_o      (off),
    .spec_o     (spec),
    .cfg0_o     (cfg0),
    .cfg1_o     (cfg1),
    .xaddr_o    (xaddr)
  );

  hpc_type_sel u_sel (
    .acc_valid_i   (acc_valid_i),
    .acc_wr_i      (acc_wr_i),
    .iack_hit_i    (iack_hit),
    .cfg_data_wr_i (cfg_data_wr_i),
    .off_i         (off),
    .spec_i        (spec),
    .cfg0_i        (cfg0),
    .cfg1_i        (cfg1),
    .xaddr_i       (xaddr),
    .type_o        (type_d),
    .addr_o        (addr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_type_o <= '0;
      cfg_addr_o <= '0;
    end else begin
      cyc_type_o <= type_d;
      cfg_addr_o <= addr_d;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk_i) !rst_ni |-> (cyc_type_o == '0 && cfg_addr_o == '0)); // R1
  AST_ONEHOT0: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(cyc_type_o)); // R9
  AST_STROBE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i || cfg_data_wr_i) |=> $countones(cyc_type_o) == 1); // R9
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_valid_i && !cfg_data_wr_i) |=> (cyc_type_o == '0 && cfg_addr_o == '0)); // R9
  AST_WRITE_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !cfg_data_wr_i && acc_wr_i && iack_hit) |=> cyc_type_o[CT_ERR]); // R4
  AST_READ_IACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !cfg_data_wr_i && !acc_wr_i && iack_hit) |=> cyc_type_o[CT_IACK]); // R2
  AST_SPEC_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_type_o[CT_SPEC] |-> cfg_addr_o == '0); // R5
  AST_CFG1_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_type_o[CT_CFG1] |-> cfg_addr_o[1:0] == 2'b01); // R6
  AST_CFG0_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_type_o[CT_CFG0] |-> (cfg_addr_o[1:0] == 2'b00 && $countones(cfg_addr_o[ADDR_W-1:IDSEL_LSB]) <= 1)); // R7
  AST_CFG_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_data_wr_i && !cfg_addr_i[31]) |=> cyc_type_o[CT_PASS]); // R8
  AST_CFG_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_data_wr_i |=> (!cyc_type_o[CT_IACK] && !cyc_type_o[CT_ERR])); // R10
endmodule

// File: tb/sim_hpc_cycle_classifier.sv
module sim_hpc_cycle_classifier;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  localparam logic [5:0] T_NONE = 6'b000000;
  localparam logic [5:0] T_PASS = 6'b000001;
  localparam logic [5:0] T_IACK = 6'b000010;
  localparam logic [5:0] T_SPEC = 6'b000100;
  localparam logic [5:0] T_CFG0 = 6'b001000;
  localparam logic [5:0] T_CFG1 = 6'b010000;
  localparam logic [5:0] T_ERR  = 6'b100000;

  typedef struct packed {
    logic        acc;
    logic        cfgw;
    logic        wr;
    logic        mapb;
    logic [31:0] addr;
    logic [31:0] cfga;
    logic [5:0]  etype;
    logic [31:0] eaddr;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0,32'hBFFF_FFF0,32'h0,T_IACK,32'h0},        // R2 low edge
    '{1'b1,1'b0,1'b0,1'b0,32'hBFFF_FFFF,32'h0,T_IACK,32'h0},        // R2 high edge
    '{1'b1,1'b0,1'b0,1'b0,32'hBFFF_FFEF,32'h0,T_PASS,32'h0},        // R2 below
    '{1'b1,1'b0,1'b1,1'b0,32'hBFFF_FFF8,32'h0,T_ERR,32'h0},         // R4 map A write
    '{1'b1,1'b0,1'b0,1'b0,32'hFEF0_0000,32'h0,T_PASS,32'h0},        // R2 other window
    '{1'b1,1'b0,1'b0,1'b1,32'hFEF0_0000,32'h0,T_IACK,32'h0},        // R3 low edge
    '{1'b1,1'b0,1'b0,1'b1,32'hFEFF_FFFF,32'h0,T_IACK,32'h0},        // R3 high edge
    '{1'b1,1'b0,1'b0,1'b1,32'hFF00_0000,32'h0,T_PASS,32'h0},        // R3 above
    '{1'b1,1'b0,1'b0,1'b1,32'hFEEF_FFFF,32'h0,T_PASS,32'h0},        // R3 below
    '{1'b1,1'b0,1'b1,1'b1,32'hFEF8_0000,32'h0,T_ERR,32'h0},         // R4 map B write
    '{1'b1,1'b0,1'b0,1'b1,32'hBFFF_FFF0,32'h0,T_PASS,32'h0},        // R3 other window
    '{1'b1,1'b0,1'b1,1'b1,32'h1234_5678,32'h0,T_PASS,32'h0},        // R4 write outside
    '{1'b0,1'b1,1'b1,1'b0,32'h0,32'h8000_1110,T_CFG0,32'h0000_2110}, // R7 dev2 fn1 reg4
    '{1'b0,1'b1,1'b1,1'b0,32'h0,32'h8000_FF00,T_SPEC,32'h0},        // R5 pattern
    '{1'b0,1'b1,1'b1,1'b0,32'h0,32'h8000_FF04,T_CFG0,32'h0000_0704}, // R5 reg nonzero
    '{1'b0,1'b1,1'b1,1'b0,32'h0,32'h8005_1A40,T_CFG1,32'h0005_1A41}, // R6 bus 5
    '{1'b0,1'b1,1'b1,1'b0,32'h0,32'h80FF_FF00,T_CFG1,32'h00FF_FF01}, // R6 pattern remote
    '{1'b0,1'b1,1'b1,1'b0,32'h0,32'h0000_FF00,T_PASS,32'h0},        // R8 disabled
    '{1'b0,1'b1,1'b1,1'b0,32'h0,32'h8000_FE00,T_CFG0,32'h0000_0600}, // R5 fn 6
    '{1'b1,1'b1,1'b1,1'b0,32'hBFFF_FFF0,32'h8000_0800,T_CFG0,32'h0000_1000}, // R10
    '{1'b0,1'b0,1'b1,1'b0,32'hBFFF_FFF0,32'h8000_FF00,T_NONE,32'h0}, // R9 idle
    '{1'b0,1'b1,1'b1,1'b0,32'h0,32'h8000_A000,T_CFG0,32'h8000_0000}, // R7 dev 20
    '{1'b0,1'b1,1'b1,1'b0,32'h0,32'h8000_A800,T_CFG0,32'h0000_0000}, // R7 dev 21
    '{1'b0,1'b1,1'b1,1'b0,32'h0,32'h8001_0000,T_CFG1,32'h0001_0001}  // R6 bus 1
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_wr = 1'b0, map_b = 1'b0, cfg_wr = 1'b0;
  logic [31:0] acc_addr = '0, cfg_addr = '0;
  logic [5:0]  cyc_type;
  logic [31:0] xaddr;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hpc_cycle_classifier u0 (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(acc_valid), .acc_wr_i(acc_wr),
    .acc_addr_i(acc_addr), .map_b_i(map_b), .cfg_data_wr_i(cfg_wr),
    .cfg_addr_i(cfg_addr), .cyc_type_o(cyc_type), .cfg_addr_o(xaddr)
  );

  task automatic check(input string req, input logic [5:0] et, input logic [31:0] ea);
    checks++;
    if (cyc_type !== et || xaddr !== ea) begin
      fails++;
      $display("FAIL %s: type=%b addr=%h expected type=%b addr=%h", req, cyc_type, xaddr, et, ea);
    end
  endtask

  task automatic drive(input vec_t v);
    acc_valid = v.acc; cfg_wr = v.cfgw; acc_wr = v.wr; map_b = v.mapb;
    acc_addr = v.addr; cfg_addr = v.cfga;
  endtask

  task automatic idle();
    acc_valid = 1'b0; cfg_wr = 1'b0; acc_wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", T_NONE, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", T_NONE, 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      @(negedge clk);
      check($sformatf("vec %0d", i), TBL[i].etype, TBL[i].eaddr);
    end

    // R9 back-to-back with differing types, one-cycle latency
    drive(TBL[15]);
    @(negedge clk);
    drive(TBL[0]);
    check("R9 b2b cfg1", T_CFG1, 32'h0005_1A41);
    @(negedge clk);
    idle();
    check("R9 b2b iack", T_IACK, 32'h0);
    @(negedge clk);
    check("R9 idle after", T_NONE, 32'h0);

    // R10 enable clear with a concurrent window write: still pass-through
    acc_valid = 1'b1; acc_wr = 1'b1; map_b = 1'b0; acc_addr = 32'hBFFF_FFF4;
    cfg_wr = 1'b1; cfg_addr = 32'h0000_1110;
    @(negedge clk);
    check("R10 R8 prio disabled", T_PASS, 32'h0);

    // R1 asynchronous reset mid-run
    drive(TBL[13]);
    @(negedge clk);
    check("R5 before reset", T_SPEC, 32'h0);
    #(CLK_PERIOD/4) rst_n = 1'b0;
    #1 check("R1 async clear", T_NONE, 32'h0);
    @(negedge clk);
    check("R1 held", T_NONE, 32'h0);
    idle();
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 R9 idle after reset", T_NONE, 32'h0);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: done=0 expected done=1");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule